// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is a chain of eight storage stages that captures a parallel word and then streams it out one bit at a time from its last stage. Every input, including the external shift clock, its active-low enable and the active-low load strobe, is sampled on the system clock. A shift takes place when the OR of the shift clock and the enable rises. Holding either of those two inputs high therefore freezes the chain, and the two inputs may be swapped freely.

While the load strobe is low, the stages copy the parallel word on every system clock and any shift is ignored. Once the strobe is high, each effective rising edge moves the data one stage toward the output and the serial input enters the first stage. The last stage is driven both true and inverted. Feeding the true output into the serial input of a second copy builds a longer converter.

Top module: `piso_shift_reg`

## Requirements
- R1: While `load_n_i` is 0 at a system clock edge, every stage takes the matching bit of `par_i`. The outputs show the new last stage from the next cycle onward.
- R2: While `load_n_i` is 1, each effective rising edge moves stage k to stage k+1 and puts `ser_i` into stage 0. Without such an edge the stages hold.
- R3: The effective shift clock is `shift_clk_i | clk_en_n_i`. While `clk_en_n_i` stays 1, pulses on `shift_clk_i` cause no shift.
- R4: `last_o` carries stage WIDTH-1 and `last_n_o` its inverse. After a load, bit 7 of the word appears first, followed by bits 6 down to 0 on successive shifts.
- R5: A 0-to-1 change of `clk_en_n_i` while `shift_clk_i` is 0 is itself an effective edge and causes one shift.
- R6: If `load_n_i` rises while both `shift_clk_i` and `clk_en_n_i` are 0, no shift occurs. The next shift waits for a later rise of the effective clock.
- R7: An effective edge in a cycle where `load_n_i` is 0 is ignored, and the load wins.
- R8: An active reset (`rst_n` = 0) clears all stages and the edge history, giving `last_o` = 0 and `last_n_o` = 1.
- R9: When `last_o` of one block drives `ser_i` of a second block that shares its controls, the second block emits its own 8 bits, MSB first, and then the first block's 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_clk_i | input | 1 | External shift clock, sampled |
| clk_en_n_i | input | 1 | Active-low shift enable, ORed with the shift clock |
| load_n_i | input | 1 | Active-low level-sensitive parallel load |
| ser_i | input | 1 | Serial data into stage 0 |
| par_i | input | WIDTH | Parallel word; bit k goes to stage k |
| last_o | output | 1 | Content of the last stage |
| last_n_o | output | 1 | Inverse of the last stage |

## Verification
On every cycle, the assertions check the stage update rules: load copies the word, an edge shifts, and no edge holds. They also check that a held-high enable blocks edges, that an enable release with the clock low produces an edge, that a load release with the effective clock low leaves the output unchanged, and that the inverted output tracks the loaded MSB. Only the bench's scenarios can show the complete serialization order of a word, the interplay of enable and clock toggling over long sequences, and the 16-bit order of two cascaded blocks. A reference model running under random control activity covers these.

// File: rtl/piso_pkg.sv
package piso_pkg;

    localparam int PISO_WIDTH_DEF = 8;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } piso_op_e;

    // Load is level sensitive and wins over any coincident shift edge.
    function automatic piso_op_e pick_op(input logic load_n, input logic shift_edge);
        if (!load_n)         return OP_LOAD;
        else if (shift_edge) return OP_SHIFT;
        else                 return OP_HOLD;
    endfunction

endpackage

// File: rtl/piso_gate_edge.sv
module piso_gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_clk_i,
    input  logic clk_en_n_i,
    output logic edge_o
);

    typedef struct packed {
        logic gate;
    } gate_state_t;

    gate_state_t st_d, st_q;
    logic        eff_clk;

    always_comb begin
        eff_clk    = shift_clk_i | clk_en_n_i;
        st_d       = st_q;
        st_d.gate  = eff_clk;
        edge_o     = eff_clk & ~st_q.gate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: an enable held high across two samples leaves no edge
    assert_enable_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(clk_en_n_i) && clk_en_n_i) |-> !edge_o);

    // R5: releasing the enable while the clock is low is an edge
    assert_enable_release_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !shift_clk_i && !$past(shift_clk_i) && $rose(clk_en_n_i)) |-> edge_o);

endmodule

// File: rtl/piso_stage_chain.sv
module piso_stage_chain
    import piso_pkg::*;
#(
    parameter int WIDTH = PISO_WIDTH_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n_i,
    input  logic             edge_i,
    input  logic             ser_i,
    input  logic [WIDTH-1:0] par_i,
    output logic [WIDTH-1:0] stages_o
);

    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] stages;
    } chain_state_t;

    chain_state_t st_d, st_q;
    piso_op_e     op;

    always_comb begin
        st_d = st_q;
        op   = pick_op(load_n_i, edge_i);
        case (op)
            OP_LOAD:  st_d.stages = par_i;
            OP_SHIFT: st_d.stages = {st_q.stages[TOP-1:0], ser_i};
            default:  st_d.stages = st_q.stages;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stages_o = st_q.stages;

    // R1, R7: a low load strobe copies the word whatever the edge does
    assert_load_copies_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n_i |=> stages_o == $past(par_i));

    // R2: an edge with the load released shifts by one toward the output
    assert_edge_shifts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n_i && edge_i) |=> stages_o == {$past(stages_o[TOP-1:0]), $past(ser_i)});

    // R2: without an edge the chain holds
    assert_no_edge_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n_i && !edge_i) |=> $stable(stages_o));

endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg
    import piso_pkg::*;
#(
    parameter int WIDTH = PISO_WIDTH_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_clk_i,
    input  logic             clk_en_n_i,
    input  logic             load_n_i,
    input  logic             ser_i,
    input  logic [WIDTH-1:0] par_i,
    output logic             last_o,
    output logic             last_n_o
);

    localparam int TOP = WIDTH - 1;

    logic             shift_edge;
    logic [WIDTH-1:0] stages;

    piso_gate_edge u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .shift_clk_i (shift_clk_i),
        .clk_en_n_i  (clk_en_n_i),
        .edge_o      (shift_edge)
    );

    piso_stage_chain #(.WIDTH(WIDTH)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_n_i (load_n_i),
        .edge_i   (shift_edge),
        .ser_i    (ser_i),
        .par_i    (par_i),
        .stages_o (stages)
    );

    assign last_o   = stages[TOP];
    assign last_n_o = ~stages[TOP];

    // R4: the inverted output reflects the loaded MSB one cycle later
    assert_inverse_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n_i |=> last_n_o == ~$past(par_i[TOP]));

    // R6: releasing load with the effective clock low does not move data
    assert_release_low_no_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(load_n_i) && !shift_clk_i && !clk_en_n_i)
        |=> last_o == $past(last_o));

endmodule

// File: tb/tb_piso_shift_reg.sv
module tb_piso_shift_reg;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         cp_s, en_n_s, ld_n_s, ser_s, ser_up_s, casc_s;
    logic [W-1:0] par_lo_s, par_up_s;
    logic         lo_last, lo_last_n, up_last, up_last_n, lo_ser;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [W-1:0] m_lo, m_up;
    logic         m_gate;

    always #2 clk = ~clk;

    assign lo_ser = casc_s ? up_last : ser_s;

    piso_shift_reg #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .shift_clk_i(cp_s), .clk_en_n_i(en_n_s),
        .load_n_i(ld_n_s), .ser_i(lo_ser), .par_i(par_lo_s),
        .last_o(lo_last), .last_n_o(lo_last_n)
    );

    piso_shift_reg #(.WIDTH(W)) dut_up (
        .clk(clk), .rst_n(rst_n), .shift_clk_i(cp_s), .clk_en_n_i(en_n_s),
        .load_n_i(ld_n_s), .ser_i(ser_up_s), .par_i(par_up_s),
        .last_o(up_last), .last_n_o(up_last_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] shifted(input logic [W-1:0] v, input logic s);
        return {v[W-2:0], s};
    endfunction

    task automatic model_step();
        logic eff, edg;
        logic [W-1:0] nlo, nup;
        eff = cp_s | en_n_s;
        edg = eff & ~m_gate;
        m_gate = eff;
        nlo = m_lo; nup = m_up;
        if (!ld_n_s) begin
            nlo = par_lo_s; nup = par_up_s;
        end else if (edg) begin
            nlo = shifted(m_lo, casc_s ? m_up[W-1] : ser_s);
            nup = shifted(m_up, ser_up_s);
        end
        m_lo = nlo; m_up = nup;
    endtask

    task automatic tick(input string req);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(req, lo_last, m_lo[W-1]);
        check(req, lo_last_n, ~m_lo[W-1]);
        check(req, up_last, m_up[W-1]);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #800000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [W-1:0] wa, wb;
        void'($urandom(32'd4711));
        rst_n = 0; cp_s = 0; en_n_s = 0; ld_n_s = 1; ser_s = 0; ser_up_s = 0;
        casc_s = 0; par_lo_s = 8'hFF; par_up_s = 8'hFF;
        m_lo = '0; m_up = '0; m_gate = 0;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8", lo_last, 1'b0);
        check("R8", lo_last_n, 1'b1);
        rst_n = 1;

        // R4: serialization order, MSB first, ser_i = 0
        wa = 8'hA5; par_lo_s = wa; par_up_s = 8'h3C; ld_n_s = 0;
        tick("R1");
        check("R1", lo_last, wa[7]);
        ld_n_s = 1;
        tick("R6");
        for (int k = 1; k < W; k++) begin
            cp_s = 1; tick("R2");
            check("R4", lo_last, wa[W-1-k]);
            check("R4", lo_last_n, ~wa[W-1-k]);
            cp_s = 0; tick("R2");
        end
        cp_s = 1; tick("R2");
        check("R2", lo_last, 1'b0);

        // R3: enable high (raised while clock high) blocks clock pulses
        wa = 8'h96; par_lo_s = wa; ld_n_s = 0; tick("R1");
        ld_n_s = 1; tick("R1");
        en_n_s = 1; tick("R3");
        for (int k = 0; k < 4; k++) begin
            cp_s = 0; tick("R3");
            cp_s = 1; tick("R3");
            check("R3", lo_last, wa[7]);
        end
        en_n_s = 0; tick("R3");
        check("R3", lo_last, wa[7]);

        // R5: enable release with clock low shifts once
        cp_s = 0; tick("R5");
        check("R5", lo_last, wa[7]);
        en_n_s = 1; tick("R5");
        check("R5", lo_last, wa[6]);
        en_n_s = 0; tick("R5");

        // R6: load released with effective clock low: no shift until later rise
        wa = 8'h5A; par_lo_s = wa; ld_n_s = 0; tick("R6");
        ld_n_s = 1; tick("R6");
        check("R6", lo_last, wa[7]);
        tick("R6");
        check("R6", lo_last, wa[7]);
        cp_s = 1; tick("R6");
        check("R6", lo_last, wa[6]);
        cp_s = 0; tick("R6");

        // R7: edge during load is ignored
        par_lo_s = 8'h00; ld_n_s = 0; tick("R7");
        wb = 8'hC3; par_lo_s = wb; cp_s = 1; tick("R7");
        check("R7", lo_last, wb[7]);
        ld_n_s = 1; tick("R7");
        check("R7", lo_last, wb[7]);
        cp_s = 0; tick("R7");
        cp_s = 1; tick("R7");
        check("R7", lo_last, wb[6]);
        cp_s = 0; tick("R7");

        // R9: two-block cascade, 16-bit order
        casc_s = 1; wa = 8'hB4; wb = 8'h6D; par_lo_s = wa; par_up_s = wb; ld_n_s = 0;
        tick("R9");
        ld_n_s = 1; tick("R9");
        check("R9", lo_last, wa[7]);
        for (int k = 1; k < 2*W; k++) begin
            cp_s = 1; tick("R9");
            check("R9", lo_last, (k < W) ? wa[W-1-k] : wb[2*W-1-k]);
            cp_s = 0; tick("R9");
        end
        casc_s = 0;

        // R2: random control activity against the model
        for (int i = 0; i < 3000; i++) begin
            cp_s     = $urandom_range(0, 1);
            en_n_s   = ($urandom_range(0, 3) == 0);
            ld_n_s   = ($urandom_range(0, 7) != 0);
            ser_s    = $urandom_range(0, 1);
            ser_up_s = $urandom_range(0, 1);
            casc_s   = ($urandom_range(0, 1) == 0);
            par_lo_s = W'($urandom);
            par_up_s = W'($urandom);
            tick("R2");
        end

        // R8: reset mid-run
        rst_n = 0; m_lo = '0; m_up = '0; m_gate = 0;
        @(negedge clk);
        check("R8", lo_last, 1'b0);
        check("R8", lo_last_n, 1'b1);
        check("R8", up_last_n, 1'b1);
        finish_run();
    end

endmodule